// File: doc/BRIEF.md
# Sequential Non-Trapping Integer Divider

This block computes an integer quotient or remainder over several clock cycles for a general-purpose core. A request carries a dividend, a divisor and three selectors: signed or unsigned operands, quotient or remainder, and full-width or 32-bit word operation. One unsigned shift-and-subtract engine serves every kind of request. It produces one quotient bit per cycle. A small conditioning stage turns signed operands into magnitudes before the engine runs, and a fixup stage restores the signs afterwards. No operation traps. Division by zero and the signed overflow case (most negative value divided by minus one) give fixed, defined results. These results are not produced by a separate shortcut. They come out of the unsigned engine running its normal iterations on a zero divisor, together with the ordinary sign rules.

The request side is a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a request is in flight, `req_ready` is low and `req_valid` is ignored. The caller must hold off, which is how the pipeline stalls on `busy`. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse, so the consumer must take `rsp_data` in that cycle or read it later. `rsp_data` holds its value until a later operation completes.

Top module: `seq_divider`

## Requirements
- R1: `req_ready` is high exactly when no operation is in flight. A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_valid` asserted while `req_ready` is low has no effect on timing or on any result.
- R2: Let n be 32 when `req_word`=1 and XLEN otherwise. `rsp_valid` is high for exactly one cycle, and that cycle is n+2 cycles after the accept cycle.
- R3: `busy` is high from the cycle after accept through the cycle before `rsp_valid`. It is low otherwise, and always equals the inverse of `req_ready`.
- R4: In signed mode with a nonzero divisor and no overflow, the quotient is the exact quotient truncated toward zero.
- R5: In signed mode with a nonzero divisor, a nonzero remainder has the sign of the dividend, and dividend = divisor × quotient + remainder.
- R6: An unsigned divide by zero returns all ones as the quotient and the dividend as the remainder.
- R7: A signed divide by zero returns −1 as the quotient and the dividend as the remainder.
- R8: A signed most-negative dividend divided by −1 returns the most negative value as the quotient and 0 as the remainder.
- R9: With `req_word`=1, only bits [31:0] of each operand are used. The 32-bit result is sign-extended to XLEN bits on every path, including divide by zero and overflow.
- R10: After reset, `rsp_valid`=0, `busy`=0 and `rsp_data`=0. `rsp_data` changes only in a cycle where `rsp_valid` is high.
- R11: Encoding of the selectors: `req_signed`=1 reads the operands as two's complement and 0 reads them as unsigned; `req_rem`=1 returns the remainder and 0 returns the quotient; `req_word`=1 selects 32-bit operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_dividend | input | XLEN | Dividend |
| req_divisor | input | XLEN | Divisor |
| req_signed | input | 1 | 1: two's complement operands |
| req_rem | input | 1 | 1: return remainder, 0: quotient |
| req_word | input | 1 | 1: 32-bit operation, sign-extended result |
| busy | output | 1 | Operation in flight, stall the pipeline |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | XLEN | Result, held until the next completion |

## Verification
The bench builds the unit with XLEN = 64. At that width the full-width path runs 64 iterations and the word path runs 32, so both iteration counts are exercised. The word path can be given operands whose upper 32 bits are garbage, and the upper bits of every word result can be checked for sign extension. At this width, 64-bit division by zero and the 64-bit and 32-bit overflow corners are all reachable in the same run. Requests are also raised while the unit is busy, to show they are dropped.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  // Post-processing controls latched at accept time
  typedef struct packed {
    logic neg_quo;
    logic neg_rem;
    logic want_rem;
    logic word;
  } div_fix_t;

endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  input  logic            is_signed,
  input  logic            word,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg_quo,
  output logic            neg_rem
);
  localparam bit WORD_OK = (XLEN > 32);

  logic sa, sb, b_zero;

  generate
    if (WORD_OK) begin : g_word
      logic [31:0] wa, wb;
      always_comb begin
        if (word) begin
          sa     = is_signed & dividend[31];
          sb     = is_signed & divisor[31];
          wa     = sa ? (32'd0 - dividend[31:0]) : dividend[31:0];
          wb     = sb ? (32'd0 - divisor[31:0])  : divisor[31:0];
          mag_a  = {{(XLEN-32){1'b0}}, wa};
          mag_b  = {{(XLEN-32){1'b0}}, wb};
          b_zero = (divisor[31:0] == 32'd0);
        end else begin
          sa     = is_signed & dividend[XLEN-1];
          sb     = is_signed & divisor[XLEN-1];
          wa     = '0;
          wb     = '0;
          mag_a  = sa ? ('0 - dividend) : dividend;
          mag_b  = sb ? ('0 - divisor)  : divisor;
          b_zero = (divisor == '0);
        end
      end
    end else begin : g_full
      always_comb begin
        sa     = is_signed & dividend[XLEN-1];
        sb     = is_signed & divisor[XLEN-1];
        mag_a  = sa ? ('0 - dividend) : dividend;
        mag_b  = sb ? ('0 - divisor)  : divisor;
        b_zero = (divisor == '0) | word & 1'b0;
      end
    end
  endgenerate

  // quotient sign flips only for a real (nonzero) divisor of opposite sign
  assign neg_quo = (sa ^ sb) & ~b_zero;
  // remainder follows the dividend
  assign neg_rem = sa;

endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            word,
  input  logic [XLEN-1:0] mag_a,
  input  logic [XLEN-1:0] mag_b,
  output logic            last,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);
  localparam bit WORD_OK = (XLEN > 32);
  localparam int CW      = $clog2(XLEN + 1);
  localparam logic [CW-1:0] N_FULL = CW'(XLEN);
  localparam logic [CW-1:0] N_WORD = CW'(32);

  logic [XLEN-1:0] acc_q, shq_q, dvs_q;
  logic [CW-1:0]   cnt_q;
  logic            active;

  logic [XLEN:0]   shifted, diff;
  logic            ge;
  logic [XLEN-1:0] preload;

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == CW'(1));

  // one restoring step: shift in next dividend bit, try to subtract
  always_comb begin
    shifted = {acc_q, shq_q[XLEN-1]};
    diff    = shifted - {1'b0, dvs_q};
    ge      = ~diff[XLEN];
  end

  generate
    if (WORD_OK) begin : g_pre
      // word mode: put the 32 live bits at the top so 32 steps suffice
      assign preload = word ? {mag_a[31:0], {(XLEN-32){1'b0}}} : mag_a;
    end else begin : g_pre_full
      assign preload = mag_a;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      shq_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      acc_q <= '0;
      shq_q <= preload;
      dvs_q <= mag_b;
      cnt_q <= (WORD_OK && word) ? N_WORD : N_FULL;
    end else if (active) begin
      acc_q <= ge ? diff[XLEN-1:0] : shifted[XLEN-1:0];
      shq_q <= {shq_q[XLEN-2:0], ge};
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign quo = shq_q;
  assign rem = acc_q;

  // R5: after the last step the partial remainder is below a nonzero divisor
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && (dvs_q != '0)) |-> (acc_q < dvs_q));

  // R2: the step counter only moves down by one while running
  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/div_post.sv
module div_post #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]    quo,
  input  logic [XLEN-1:0]    rem,
  input  div_pkg::div_fix_t  fix,
  output logic [XLEN-1:0]    result
);
  localparam bit WORD_OK = (XLEN > 32);

  logic [XLEN-1:0] pick, signed_val;
  logic            neg;

  always_comb begin
    pick       = fix.want_rem ? rem : quo;
    neg        = fix.want_rem ? fix.neg_rem : fix.neg_quo;
    signed_val = neg ? ('0 - pick) : pick;
  end

  generate
    if (WORD_OK) begin : g_sext
      assign result = fix.word ? {{(XLEN-32){signed_val[31]}}, signed_val[31:0]}
                               : signed_val;
    end else begin : g_plain
      assign result = signed_val;
    end
  endgenerate

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_dividend,
  input  logic [XLEN-1:0] req_divisor,
  input  logic            req_signed,
  input  logic            req_rem,
  input  logic            req_word,
  output logic            busy,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data
);
  import div_pkg::*;

  localparam bit WORD_OK = (XLEN > 32);

  div_state_e      state_q;
  div_fix_t        fix_q;
  logic            accept;
  logic [XLEN-1:0] mag_a, mag_b, core_quo, core_rem, post_res;
  logic            neg_quo, neg_rem, core_last;
  logic            word_eff;

  assign word_eff  = WORD_OK & req_word;
  assign req_ready = (state_q == ST_IDLE);
  assign busy      = ~req_ready;
  assign accept    = req_valid & req_ready;

  div_prep #(.XLEN(XLEN)) u_prep (
    .dividend (req_dividend),
    .divisor  (req_divisor),
    .is_signed(req_signed),
    .word     (word_eff),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .neg_quo  (neg_quo),
    .neg_rem  (neg_rem)
  );

  div_core #(.XLEN(XLEN)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .word (word_eff),
    .mag_a(mag_a),
    .mag_b(mag_b),
    .last (core_last),
    .quo  (core_quo),
    .rem  (core_rem)
  );

  div_post #(.XLEN(XLEN)) u_post (
    .quo   (core_quo),
    .rem   (core_rem),
    .fix   (fix_q),
    .result(post_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      fix_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          fix_q   <= '{neg_quo:  neg_quo,
                       neg_rem:  neg_rem,
                       want_rem: req_rem,
                       word:     word_eff};
        end
        ST_RUN:  if (core_last) state_q <= ST_FIX;
        ST_FIX: begin
          rsp_data  <= post_res;
          rsp_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: a request raised while busy leaves the latched controls untouched
  a_r1_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(fix_q));

  // R2: the result strobe is a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3: busy only drops together with the result strobe
  a_r3_busy_ends_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  // R10: result register holds between strobes
  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_data));

  generate
    if (WORD_OK) begin : g_word_chk
      // R9: word results are sign-extended on every path
      a_r9_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fix_q.word) |-> (rsp_data[XLEN-1:32] == {(XLEN-32){rsp_data[31]}}));
    end
  endgenerate

endmodule

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [XLEN-1:0] req_dividend = '0;
  logic [XLEN-1:0] req_divisor = '0;
  logic            req_signed = 1'b0;
  logic            req_rem = 1'b0;
  logic            req_word = 1'b0;
  logic            busy;
  logic            rsp_valid;
  logic [XLEN-1:0] rsp_data;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  seq_divider #(.XLEN(XLEN)) u0 (.*);

  // ---------------- behavioural reference ----------------
  function automatic logic [63:0] ref_div(input logic [63:0] a, input logic [63:0] b,
                                          input logic s, input logic r, input logic w);
    logic [63:0] q, m;
    if (w) begin
      logic [31:0] a32, b32, qw, mw;
      a32 = a[31:0];
      b32 = b[31:0];
      if (b32 == 32'd0) begin
        qw = s ? 32'hFFFF_FFFF : 32'hFFFF_FFFF;
        mw = a32;
      end else if (s && a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF) begin
        qw = a32;
        mw = 32'd0;
      end else if (s) begin
        qw = 32'($signed(a32) / $signed(b32));
        mw = 32'($signed(a32) % $signed(b32));
      end else begin
        qw = a32 / b32;
        mw = a32 % b32;
      end
      q = {{32{qw[31]}}, qw};
      m = {{32{mw[31]}}, mw};
    end else begin
      if (b == 64'd0) begin
        q = '1;
        m = a;
      end else if (s && a == 64'h8000_0000_0000_0000 && b == '1) begin
        q = a;
        m = 64'd0;
      end else if (s) begin
        q = 64'($signed(a) / $signed(b));
        m = 64'($signed(a) % $signed(b));
      end else begin
        q = a / b;
        m = a % b;
      end
    end
    return r ? m : q;
  endfunction

  function automatic string tag_of(input logic [63:0] a, input logic [63:0] b,
                                   input logic s, input logic r, input logic w);
    if (w) return "R9";
    if (b == 64'd0) return s ? "R7" : "R6";
    if (s && a == 64'h8000_0000_0000_0000 && b == '1) return "R8";
    if (!s) return "R11";
    return r ? "R5" : "R4";
  endfunction

  int          m_cnt = 0;
  logic        m_valid = 1'b0;
  logic [63:0] m_data = '0;
  logic [63:0] m_pend = '0;
  string       m_tag = "R10";
  string       m_pend_tag = "R10";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_valid = 1'b0; m_data = '0; m_tag = "R10";
    end else begin
      m_valid = 1'b0;
      if (m_cnt == 0) begin
        if (req_valid) begin
          m_cnt      = (req_word ? 32 : XLEN) + 1;
          m_pend     = ref_div(req_dividend, req_divisor, req_signed, req_rem, req_word);
          m_pend_tag = tag_of(req_dividend, req_divisor, req_signed, req_rem, req_word);
        end
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_valid = 1'b1;
          m_data  = m_pend;
          m_tag   = m_pend_tag;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    chk("R1 ready", {63'd0, req_ready}, {63'd0, m_cnt == 0});
    chk("R3 busy", {63'd0, busy}, {63'd0, m_cnt != 0});
    chk("R2 strobe", {63'd0, rsp_valid}, {63'd0, m_valid});
    if (m_valid) chk(m_tag, rsp_data, m_data);
    else         chk("R10 hold", rsp_data, m_data);
  end

  // ---------------- stimulus ----------------
  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic s, input logic r, input logic w, input bit poke);
    @(negedge clk);
    req_dividend = a; req_divisor = b;
    req_signed = s; req_rem = r; req_word = w;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (m_cnt != 0) begin
      if (poke) begin  // R1: requests while busy must be dropped
        req_valid = 1'b1;
        req_dividend = ~a; req_divisor = b ^ 64'h5;
        req_rem = ~r; req_word = ~w;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  task automatic both(input logic [63:0] a, input logic [63:0] b,
                      input logic s, input logic w, input bit poke);
    run_op(a, b, s, 1'b0, w, poke);
    run_op(a, b, s, 1'b1, w, poke);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                        // R10 reset state checked every cycle
    both(64'd100, 64'd7, 1'b0, 1'b0, 1'b0);          // R11 unsigned
    both(-64'sd100, 64'd7, 1'b1, 1'b0, 1'b0);        // R4 R5
    both(64'd100, -64'sd7, 1'b1, 1'b0, 1'b0);
    both(-64'sd100, -64'sd7, 1'b1, 1'b0, 1'b1);      // R1 poke while busy
    both(-64'sd12345, 64'd0, 1'b1, 1'b0, 1'b0);      // R7
    both(64'hDEAD_BEEF_0000_1234, 64'd0, 1'b0, 1'b0, 1'b0); // R6
    both(MIN64, '1, 1'b1, 1'b0, 1'b0);               // R8
    both(MIN64, 64'd1, 1'b1, 1'b0, 1'b0);
    both(64'hFFFF_FFFF_8000_0000, 64'h1234_5678_FFFF_FFFF, 1'b1, 1'b1, 1'b0); // R9 overflow
    both(64'h0000_0000_8000_0001, 64'hAAAA_0000_0000_0000, 1'b0, 1'b1, 1'b0); // R9 div by zero
    both(64'h7777_7777_8000_0001, 64'd0, 1'b1, 1'b1, 1'b1);  // R9 signed zero divisor
    both(64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 1'b1, 1'b1, 1'b0);
    both(64'd3, 64'd10, 1'b1, 1'b0, 1'b0);
    both(64'd0, 64'd5, 1'b1, 1'b0, 1'b0);
    both('1, '1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 3 == 1) b = b >> (b[5:0]);
      if (i % 7 == 2) b = '0;
      run_op(a, b, i[0], i[1], i[2], i[3] & i[4]);
    end
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule